// File: doc/BRIEF.md
# Bidirectional-Bus Universal Shift Register

This block is a storage register, eight bits wide by default, that can hold its contents, shift toward the high end, shift toward the low end, or load a full word in parallel. The parallel load data and the parallel output share one bidirectional bus. That bus is presented as three plain signals so that it synthesizes cleanly: an input word, an output word and a single drive-enable. The pad or a bus resolver outside the block turns these into a tri-state pin.

Two active-low enables must both be asserted before the block drives the bus. The block also releases the bus while it is in load mode, so it never contends with the device that is supplying the data. Two serial outputs always carry the lowest and highest register bits, whatever the enables say. These outputs let several registers be chained into a longer shift path. An active-low asynchronous reset clears the register at once and holds it clear.

Top module: `shift8_bidir`

## Requirements
- R1: With mode 2'b00, the register keeps its value across a rising clock edge. This is true whatever the serial inputs, the bus input and the enables are doing.
- R2: With mode 2'b01, a rising edge shifts toward the high end. Bit 0 takes `ser_r_in` and bit n takes the old bit n-1.
- R3: With mode 2'b10, a rising edge shifts toward the low end. The top bit takes `ser_l_in` and bit n takes the old bit n+1.
- R4: With mode 2'b11, a rising edge copies `bus_in` into the register.
- R5: While `rst_n` is low, the register is zero. It clears without waiting for a clock edge, and clock edges and mode values have no effect while reset is held.
- R6: `bus_oe` is high only when `oe_a_n` and `oe_b_n` are both low and the mode is not 2'b11. In every other case the bus is released.
- R7: While `bus_oe` is high, `bus_out` presents the stored register value.
- R8: `ser_lo_out` always equals register bit 0 and `ser_hi_out` always equals the top register bit, independent of both enables.
- R9: Two instances can be chained by feeding `ser_hi_out` of the lower one into `ser_r_in` of the upper one. Sixteen right shifts then move a 16-bit serial stream across both, with the first bit sent ending in the upper instance's top bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous clear, active low |
| mode | input | 2 | Operation select: 00 hold, 01 shift up, 10 shift down, 11 load |
| ser_r_in | input | 1 | Serial bit entering bit 0 on a shift up |
| ser_l_in | input | 1 | Serial bit entering the top bit on a shift down |
| oe_a_n | input | 1 | First bus enable, active low |
| oe_b_n | input | 1 | Second bus enable, active low |
| bus_in | input | WIDTH | Word sampled from the shared bus |
| bus_out | output | WIDTH | Word presented to the shared bus |
| bus_oe | output | 1 | Drive enable for the shared bus |
| ser_lo_out | output | 1 | Always-on copy of bit 0 |
| ser_hi_out | output | 1 | Always-on copy of the top bit |

## Verification
A wrong stored bit shows on the bus as soon as the enables are low in a non-load mode, in the cycle after the faulty edge. A corrupted end bit reaches the serial outputs in that same cycle, whether or not the bus is enabled. A shift that sends bits the wrong way, or drops the serial input, leaves a pattern that differs from the expected word on the next readback. A drive-enable that stays on during load mode shows up as a collision with the external driver in the cycle it occurs.

// File: rtl/shift8_bidir.sv
module shift8_bidir #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic             ser_r_in,
  input  logic             ser_l_in,
  input  logic             oe_a_n,
  input  logic             oe_b_n,
  input  logic [WIDTH-1:0] bus_in,
  output logic [WIDTH-1:0] bus_out,
  output logic             bus_oe,
  output logic             ser_lo_out,
  output logic             ser_hi_out
);
  localparam int TOP = WIDTH - 1;
  localparam logic [1:0] M_HOLD = 2'b00;
  localparam logic [1:0] M_UP   = 2'b01;
  localparam logic [1:0] M_DOWN = 2'b10;
  localparam logic [1:0] M_LOAD = 2'b11;

  logic [WIDTH-1:0] q, q_nx;

  always_comb begin
    case (mode)
      M_UP:    q_nx = {q[TOP-1:0], ser_r_in};
      M_DOWN:  q_nx = {ser_l_in, q[TOP:1]};
      M_LOAD:  q_nx = bus_in;
      default: q_nx = q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nx;
  end

  assign bus_out    = q;
  assign bus_oe     = !oe_a_n && !oe_b_n && (mode != M_LOAD);
  assign ser_lo_out = q[0];
  assign ser_hi_out = q[TOP];

  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mode == M_HOLD |=> $stable(bus_out));

  a_r2_shift_up: assert property (@(posedge clk) disable iff (!rst_n)
    mode == M_UP |=> bus_out == {$past(bus_out[TOP-1:0]), $past(ser_r_in)});

  a_r3_shift_down: assert property (@(posedge clk) disable iff (!rst_n)
    mode == M_DOWN |=> bus_out == {$past(ser_l_in), $past(bus_out[TOP:1])});

  a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
    mode == M_LOAD |=> bus_out == $past(bus_in));

  always_ff @(posedge clk)
    if (!rst_n) a_r5_cleared: assert (q == '0);

  a_r6_release: assert property (@(posedge clk)
    (oe_a_n || oe_b_n || mode == M_LOAD) |-> !bus_oe);

  a_r9_serial_entry: assert property (@(posedge clk) disable iff (!rst_n)
    mode == M_UP |=> ser_lo_out == $past(ser_r_in));
endmodule

// File: tb/tb_shift8_bidir.sv
module tb_shift8_bidir;
  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic [1:0] mode = 2'b00;
  logic sr = 1'b0, sl = 1'b0;
  logic oea_n = 1'b0, oeb_n = 1'b0;
  logic ext_en = 1'b0;
  logic [7:0] ext_data = 8'h00;
  logic [7:0] lo_out, hi_out, bus_val;
  logic lo_oe, hi_oe, lo_s0, lo_s7, hi_s0, hi_s7;
  int total = 0, bad = 0, clash = 0;

  always #4 clk = ~clk;

  always_comb bus_val = ext_en ? ext_data : (lo_oe ? lo_out : 8'h00);

  shift8_bidir dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .ser_r_in(sr), .ser_l_in(sl),
    .oe_a_n(oea_n), .oe_b_n(oeb_n), .bus_in(bus_val), .bus_out(lo_out),
    .bus_oe(lo_oe), .ser_lo_out(lo_s0), .ser_hi_out(lo_s7));

  shift8_bidir dut_hi (
    .clk(clk), .rst_n(rst_n), .mode(mode), .ser_r_in(lo_s7), .ser_l_in(1'b0),
    .oe_a_n(1'b0), .oe_b_n(1'b0), .bus_in(8'h00), .bus_out(hi_out),
    .bus_oe(hi_oe), .ser_lo_out(hi_s0), .ser_hi_out(hi_s7));

  always @(negedge clk) if (ext_en && lo_oe) clash++;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] m, input logic r, input logic l, input logic [7:0] d);
    @(negedge clk);
    mode = m; sr = r; sl = l; ext_data = d; ext_en = (m == 2'b11);
    @(posedge clk);
    #1 mode = 2'b00; ext_en = 1'b0;
    #1;
  endtask

  // fields: [19:18] mode, [17] sr, [16] sl, [15:8] bus word, [7:0] expected word
  localparam int NV = 10;
  localparam logic [19:0] VEC [NV] = '{
    {2'b11, 1'b0, 1'b0, 8'hA5, 8'hA5},
    {2'b00, 1'b1, 1'b1, 8'hFF, 8'hA5},
    {2'b01, 1'b1, 1'b0, 8'h00, 8'h4B},
    {2'b01, 1'b0, 1'b1, 8'hFF, 8'h96},
    {2'b10, 1'b0, 1'b1, 8'h00, 8'hCB},
    {2'b10, 1'b0, 1'b0, 8'h00, 8'h65},
    {2'b11, 1'b0, 1'b0, 8'h3C, 8'h3C},
    {2'b00, 1'b0, 1'b0, 8'hFF, 8'h3C},
    {2'b10, 1'b0, 1'b0, 8'h00, 8'h1E},
    {2'b01, 1'b1, 1'b0, 8'h00, 8'h3D}
  };

  initial begin
    #1 rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #2;
    chk("R5 reset word", {8'h00, bus_val}, 16'h0000);
    chk("R8 reset serial", {14'h0, lo_s7, lo_s0}, 16'h0000);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][19:18], VEC[i][17], VEC[i][16], VEC[i][15:8]);
      chk($sformatf("R1-4 vec%0d (R7 bus)", i), {7'h0, lo_oe, bus_val}, {8'h01, VEC[i][7:0]});
      chk($sformatf("R8 vec%0d serial", i), {14'h0, lo_s7, lo_s0}, {14'h0, VEC[i][7], VEC[i][0]});
    end
    chk("R2 R3 R4 final word", {8'h00, lo_out}, 16'h003D);

    @(negedge clk) oea_n = 1'b1; #1;
    chk("R6 first enable off", {15'h0, lo_oe}, 16'h0000);
    chk("R8 serial with bus off", {14'h0, lo_s7, lo_s0}, 16'h0001);
    oea_n = 1'b0; oeb_n = 1'b1; #1;
    chk("R6 second enable off", {15'h0, lo_oe}, 16'h0000);
    step(2'b00, 1'b1, 1'b1, 8'h00);
    chk("R1 hold with bus off", {8'h00, lo_out}, 16'h003D);
    oeb_n = 1'b0;
    @(negedge clk) mode = 2'b11; #1;
    chk("R6 load mode releases bus", {15'h0, lo_oe}, 16'h0000);
    mode = 2'b00; #1;
    chk("R6 R7 bus driven again", {7'h0, lo_oe, bus_val}, 16'h013D);

    @(negedge clk); #1 rst_n = 1'b0; #1;
    chk("R5 async clear", {8'h00, lo_out}, 16'h0000);
    mode = 2'b11; ext_en = 1'b1; ext_data = 8'hFF; sr = 1'b1;
    @(posedge clk); #1;
    chk("R5 clock ignored in reset", {8'h00, lo_out}, 16'h0000);
    @(negedge clk) begin ext_en = 1'b0; mode = 2'b00; rst_n = 1'b1; end

    for (int b = 15; b >= 0; b--) begin
      step(2'b01, (16'hBEEF >> b) & 16'h1, 1'b0, 8'h00);
      if (b == 8) chk("R9 half cascade", {hi_out, lo_out}, 16'h00BE);
    end
    chk("R9 full cascade", {hi_out, lo_out}, 16'hBEEF);
    chk("R9 upper serial ends", {14'h0, hi_s7, hi_s0}, 16'h0002);
    chk("R6 no bus contention", clash[15:0], 16'h0000);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule